// File: doc/BRIEF.md
# Serial ADC Conversion-and-Read Controller

This block sits on the host side of a successive-approximation converter that returns its result over a serial line. A one-cycle `start` begins a transaction. The controller drives the convert/read select low for a programmed width, which starts a conversion, and holds chip select low. It then watches the converter's busy line fall and rise again. Once the conversion is over, it produces a gated data clock, derived from the system clock, and shifts in a 16-bit result, most significant bit first.

The data clock stays low while a conversion runs, so no digital edge disturbs the converter during its sensitive settling window. The sampling edge can be chosen. In falling-edge mode, 16 pulses are issued and a bit is taken on each fall. In rising-edge mode, 17 pulses are issued, a bit is taken on each rise, and the bit seen on the first rise is dropped because the word is offset by one rising edge. If the busy line misbehaves, a wait timeout ends the transaction with an error pulse instead of hanging the host.

The configuration inputs are latched when a transaction is accepted. The assembled word appears on `rd_data` together with a one-cycle `rd_valid`.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held low and on the first cycle after it, `adc_rc` and `adc_cs_n` are high, `adc_dclk`, `rd_valid` and `err_timeout` are low, and `rd_data` is zero.
- R2: A `start` seen while idle drives `adc_rc` and `adc_cs_n` low from the next cycle. `adc_rc` stays low for exactly `cfg_cnv_width`+1 cycles and then returns high.
- R3: A `start` seen while `adc_cs_n` is low is ignored: no second conversion begins, the pulse count and the word are unchanged, and `adc_rc` stays high after the transaction ends.
- R4: `adc_dclk` is low whenever `adc_cs_n` is high or `adc_rc` is low. It is never high while `adc_busy` is low. Its pulses begin only after busy has been seen low and then high again.
- R5: Every high phase of `adc_dclk`, and every low phase between two pulses, lasts `cfg_div`+1 system cycles.
- R6: With `cfg_rise_edge`=0 a transaction issues exactly 16 data clock pulses. With `cfg_rise_edge`=1 it issues exactly 17.
- R7: The word is assembled MSB first, with bit 15 the first bit kept. With `cfg_rise_edge`=0, falls 1..16 of `adc_dclk` supply bits 15..0. With `cfg_rise_edge`=1, rises 2..17 supply bits 15..0 and the value at rise 1 is discarded.
- R8: `rd_valid` is a single-cycle pulse carrying the word, and `rd_data` changes only in a cycle where `rd_valid` is high.
- R9: If busy stays high after the conversion pulse, `err_timeout` pulses exactly `cfg_cnv_width`+`cfg_timeout`+2 cycles after the edge that accepted `start`. If busy falls but never returns high, `err_timeout` also pulses. In both cases `rd_valid` stays low.
- R10: `adc_cs_n` returns high in the same cycle that `rd_valid` or `err_timeout` is high, and a later `start` runs a complete transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to convert and read |
| cfg_div | input | DIV_W | Data clock half period minus one, in system cycles |
| cfg_rise_edge | input | 1 | 1: sample on rising edges (17 pulses); 0: falling edges (16 pulses) |
| cfg_cnv_width | input | CNV_W | Convert pulse width minus one, in system cycles |
| cfg_timeout | input | TMO_W | Wait limit for each busy transition, in system cycles |
| adc_busy | input | 1 | Converter busy, low while converting |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_rc | output | 1 | Convert/read select, low to start a conversion |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_dclk | output | 1 | Gated data clock, idles low |
| rd_data | output | DATA_W | Last assembled word |
| rd_valid | output | 1 | One-cycle strobe with a new word |
| err_timeout | output | 1 | One-cycle strobe when a busy wait expires |

## Verification
The bench builds the controller with a 4-bit divider, a 4-bit convert width and an 8-bit timeout, and keeps the 16-bit word. With these widths it can sweep divider settings 0 to 3 against several convert widths and both sampling edges in a few thousand cycles. The divider-equals-zero case, where the data clock toggles every cycle, is among the settings covered. The short timeout field lets the bench predict the exact cycle of the error pulse, including a zero limit. A behavioural converter model in the bench changes its data output just after each data clock rise. This places the first-rise offset and the falling-edge window exactly where the requirements describe them.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial ADC read controller.
// Assumes: only the controller FSM uses the state encoding.
package adc_rd_pkg;

    // Transaction phases of the controller
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CONV    = 3'd1,
        ST_WAIT_LO = 3'd2,
        ST_WAIT_HI = 3'd3,
        ST_READ    = 3'd4,
        ST_DONE    = 3'd5
    } rd_state_t;

endpackage

// File: rtl/adc_rd_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for an asynchronous status input.
// Assumes: STAGES >= 2; RST_VAL is the idle level of the input.
module adc_rd_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the input through the register chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_rd_clkgen.sv
`timescale 1ns/1ps
// Gated data clock divider. While run is high the output toggles every
// half+1 system cycles, starting from low; while run is low it is held
// low and the count restarts. rise_now/fall_now flag the system edge on
// which the output register goes high/low.
// Assumes: half is stable while run is high.
module adc_rd_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             dclk,
    output logic             rise_now,
    output logic             fall_now
);

    logic [DIV_W-1:0] cnt;
    logic             dclk_q;
    logic             term;

    // Half-period terminal count reached while running
    always_comb begin
        term     = run && (cnt == half);
        rise_now = term && !dclk_q;
        fall_now = term && dclk_q;
    end

    // Half-period counter and clock output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dclk_q <= 1'b0;
        end else if (!run) begin
            cnt    <= '0;
            dclk_q <= 1'b0;
        end else if (term) begin
            cnt    <= '0;
            dclk_q <= !dclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign dclk = dclk_q;

endmodule

// File: rtl/adc_rd_shift.sv
`timescale 1ns/1ps
// Serial-to-parallel capture, MSB first. While clear is high the register
// is emptied and the skip flag is loaded; afterwards each sample strobe
// shifts in one bit, except the first one when skipping was requested.
// Assumes: W >= 2.
module adc_rd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         skip_first,
    input  logic         sample,
    input  logic         sdata,
    output logic [W-1:0] word
);

    logic [W-1:0] sr;
    logic         skip_pend;

    // Capture bits on sample strobes, dropping the first one if requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr        <= '0;
            skip_pend <= 1'b0;
        end else if (clear) begin
            sr        <= '0;
            skip_pend <= skip_first;
        end else if (sample) begin
            if (skip_pend) begin
                skip_pend <= 1'b0;
            end else begin
                sr <= {sr[W-2:0], sdata};
            end
        end
    end

    assign word = sr;

endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
// Serial ADC conversion-and-read controller (top).
// Issues a convert pulse, waits for busy to fall and rise again under a
// timeout, then clocks in DATA_W bits with a gated divided clock that is
// held low outside the read phase. Falling-edge mode issues DATA_W pulses;
// rising-edge mode issues DATA_W+1 and discards the first sample.
// Assumes: adc_busy is asynchronous and synchronized here; adc_sdata
// changes shortly after each data clock rise; configuration is latched
// on an accepted start.
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 8,
    parameter int CNV_W       = 8,
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_rise_edge,
    input  logic [CNV_W-1:0]  cfg_cnv_width,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic              adc_busy,
    input  logic              adc_sdata,
    output logic              adc_rc,
    output logic              adc_cs_n,
    output logic              adc_dclk,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_timeout
);

    localparam int PCNT_W = $clog2(DATA_W + 2);
    localparam logic [PCNT_W-1:0] LAST_FALL_MODE = PCNT_W'(DATA_W - 1);
    localparam logic [PCNT_W-1:0] LAST_RISE_MODE = PCNT_W'(DATA_W);

    rd_state_t          state, state_n;
    logic [DIV_W-1:0]   div_q;
    logic               rise_q;
    logic [CNV_W-1:0]   cnv_q;
    logic [TMO_W-1:0]   tmo_lim_q;
    logic [CNV_W-1:0]   cnv_cnt;
    logic [TMO_W-1:0]   tmo_cnt;
    logic [PCNT_W-1:0]  pulse_cnt;
    logic               busy_seen;
    logic               busy_s;
    logic               rise_now, fall_now;
    logic               pulse_last;
    logic               tmo_hit;
    logic               timeout_now;
    logic [DATA_W-1:0]  word;

    // Bring the busy status into the system clock domain
    adc_rd_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_busy_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_busy),
        .q     (busy_s)
    );

    // Data clock generator, enabled only in the read phase
    adc_rd_clkgen #(
        .DIV_W (DIV_W)
    ) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_READ),
        .half     (div_q),
        .dclk     (adc_dclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    // Serial capture on the selected sampling edge
    adc_rd_shift #(
        .W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state != ST_READ),
        .skip_first (rise_q),
        .sample     (rise_q ? rise_now : fall_now),
        .sdata      (adc_sdata),
        .word       (word)
    );

    // Decode the end of the pulse train and the wait limit
    always_comb begin
        pulse_last = rise_q ? (pulse_cnt == LAST_RISE_MODE)
                            : (pulse_cnt == LAST_FALL_MODE);
        tmo_hit    = (tmo_cnt == tmo_lim_q);
    end

    // Next-state selection and timeout detection
    always_comb begin
        state_n     = state;
        timeout_now = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) state_n = ST_CONV;
            end
            ST_CONV: begin
                if (cnv_cnt == cnv_q) state_n = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (!busy_s || busy_seen) begin
                    state_n = ST_WAIT_HI;
                end else if (tmo_hit) begin
                    state_n     = ST_IDLE;
                    timeout_now = 1'b1;
                end
            end
            ST_WAIT_HI: begin
                if (busy_s) begin
                    state_n = ST_READ;
                end else if (tmo_hit) begin
                    state_n     = ST_IDLE;
                    timeout_now = 1'b1;
                end
            end
            ST_READ: begin
                if (fall_now && pulse_last) state_n = ST_DONE;
            end
            ST_DONE: begin
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register and configuration latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            div_q     <= '0;
            rise_q    <= 1'b0;
            cnv_q     <= '0;
            tmo_lim_q <= '0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE && start) begin
                div_q     <= cfg_div;
                rise_q    <= cfg_rise_edge;
                cnv_q     <= cfg_cnv_width;
                tmo_lim_q <= cfg_timeout;
            end
        end
    end

    // Convert pulse width counter and early busy-low capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnv_cnt   <= '0;
            busy_seen <= 1'b0;
        end else if (state == ST_CONV) begin
            cnv_cnt <= cnv_cnt + 1'b1;
            if (!busy_s) busy_seen <= 1'b1;
        end else if (state == ST_IDLE) begin
            cnv_cnt   <= '0;
            busy_seen <= 1'b0;
        end
    end

    // Wait counter, restarted on every phase change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_cnt <= '0;
        end else if (state_n != state) begin
            tmo_cnt <= '0;
        end else if (state == ST_WAIT_LO || state == ST_WAIT_HI) begin
            tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    // Data clock pulse counter for the read phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (state != ST_READ) begin
            pulse_cnt <= '0;
        end else if (fall_now) begin
            pulse_cnt <= pulse_cnt + 1'b1;
        end
    end

    // Result register and completion strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            rd_valid    <= (state == ST_DONE);
            err_timeout <= timeout_now;
            if (state == ST_DONE) rd_data <= word;
        end
    end

    // Pin decodes from the registered state
    assign adc_rc   = (state != ST_CONV);
    assign adc_cs_n = (state == ST_IDLE);

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
// Protocol checker for adc_rd_ctrl, bound into every instance.
// Assumes: cfg_rise_edge is held stable during a transaction.
module adc_rd_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_rise_edge,
    input logic              adc_busy,
    input logic              adc_rc,
    input logic              adc_cs_n,
    input logic              adc_dclk,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              err_timeout
);

    localparam int CNT_W = $clog2(DATA_W + 2) + 1;

    logic [CNT_W-1:0] rise_cnt;
    logic             dclk_q;

    // Count data clock rises since the last convert pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            dclk_q   <= 1'b0;
        end else begin
            dclk_q <= adc_dclk;
            if (!adc_rc) begin
                rise_cnt <= '0;
            end else if (adc_dclk && !dclk_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    assert_rc_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rc) |-> $past(start));

    assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !adc_cs_n && adc_rc) |=> adc_rc);

    assert_dclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_cs_n || !adc_rc) |-> !adc_dclk);

    assert_dclk_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_dclk |-> adc_busy);

    assert_pulse_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rise_cnt == CNT_W'(DATA_W) + CNT_W'(cfg_rise_edge)));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

    assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_timeout && rd_valid));

    assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || err_timeout) |-> adc_cs_n);

    assert_rc_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rc |-> !adc_cs_n);

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_rise_edge (cfg_rise_edge),
    .adc_busy      (adc_busy),
    .adc_rc        (adc_rc),
    .adc_cs_n      (adc_cs_n),
    .adc_dclk      (adc_dclk),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .err_timeout   (err_timeout)
);

// File: tb/sim_adc_rd_ctrl.sv
`timescale 1ns/1ps
module sim_adc_rd_ctrl;

    localparam int DW     = 16;
    localparam int DIVW   = 4;
    localparam int CNVW   = 4;
    localparam int TMOW   = 8;
    localparam int CONV_T = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [DIVW-1:0] cfg_div = '0;
    logic            cfg_rise_edge = 1'b0;
    logic [CNVW-1:0] cfg_cnv_width = '0;
    logic [TMOW-1:0] cfg_timeout = 8'd40;
    logic            adc_busy = 1'b1;
    logic            adc_sdata = 1'b0;
    logic            adc_rc, adc_cs_n, adc_dclk, rd_valid, err_timeout;
    logic [DW-1:0]   rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    adc_rd_ctrl #(.DATA_W(DW), .DIV_W(DIVW), .CNV_W(CNVW), .TMO_W(TMOW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_div(cfg_div),
        .cfg_rise_edge(cfg_rise_edge), .cfg_cnv_width(cfg_cnv_width),
        .cfg_timeout(cfg_timeout), .adc_busy(adc_busy), .adc_sdata(adc_sdata),
        .adc_rc(adc_rc), .adc_cs_n(adc_cs_n), .adc_dclk(adc_dclk),
        .rd_data(rd_data), .rd_valid(rd_valid), .err_timeout(err_timeout));

    always #2.5 clk = ~clk;

    // Converter model: 0 normal, 1 never goes busy, 2 busy stuck low
    int            adc_mode = 0;
    int            conv_left = 0;
    logic          rc_q = 1'b1;
    logic [DW-1:0] adc_word_next = '0;
    logic [DW-1:0] adc_word_q = '0;
    int            rcnt = 0;

    always @(posedge clk) begin
        rc_q <= adc_rc;
        if (rc_q && !adc_rc && adc_mode != 1) begin
            adc_busy   <= 1'b0;
            conv_left  <= CONV_T;
            adc_word_q <= adc_word_next;
        end else if (conv_left > 0) begin
            conv_left <= conv_left - 1;
            if (conv_left == 1 && adc_mode == 0) adc_busy <= 1'b1;
        end
    end

    always @(posedge adc_dclk or negedge adc_rc) begin
        if (!adc_rc) begin
            rcnt      = 0;
            adc_sdata = 1'b0;
        end else begin
            #1;
            rcnt = rcnt + 1;
            adc_sdata = (rcnt <= DW) ? adc_word_q[DW - rcnt] : 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // One transaction with port-level monitoring at negedges
    task automatic run_txn(input logic [DW-1:0] word, input bit rise, input int div,
                           input int cw, input bit inject);
        int n = 0, rises = 0, rc_low = 0, len = 0, vcnt = 0;
        bit phase_bad = 0, busy_bad = 0, injected = 0, rc_again = 0;
        logic prev = 1'b0;
        cfg_rise_edge = rise;
        cfg_div       = DIVW'(div);
        cfg_cnv_width = CNVW'(cw);
        cfg_timeout   = 8'd40;
        adc_word_next = word;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        forever begin
            if (start) start = 1'b0;
            if (!adc_rc) rc_low++;
            if (adc_dclk && !adc_busy) busy_bad = 1;
            if (adc_dclk == prev) len++;
            else begin
                if (prev || rises > 0) if (len != div + 1) phase_bad = 1;
                if (adc_dclk) rises++;
                len = 1;
            end
            prev = adc_dclk;
            if (inject && rises == 5 && !injected) begin start = 1'b1; injected = 1; end
            if (rd_valid || err_timeout || n > 2000) break;
            @(negedge clk); n++;
        end
        check(rd_valid, "R10 completion", rd_valid, 1);
        check(rd_data == word, "R7 word", rd_data, word);
        check(rises == DW + rise, "R6 pulse count", rises, DW + rise);
        check(!phase_bad, "R5 phase length", phase_bad, 0);
        check(rc_low == cw + 1, "R2 convert width", rc_low, cw + 1);
        check(!busy_bad, "R4 clock while busy", busy_bad, 0);
        check(adc_cs_n, "R10 cs_n high at end", adc_cs_n, 1);
        vcnt = rd_valid;
        @(negedge clk);
        vcnt += rd_valid;
        check(vcnt == 1, "R8 single valid", vcnt, 1);
        if (inject) begin
            for (int i = 0; i < 12; i++) begin
                if (!adc_rc || !adc_cs_n) rc_again = 1;
                @(negedge clk);
            end
            check(!rc_again, "R3 start ignored", rc_again, 0);
        end
    endtask

    task automatic run_timeout(input int mode, input int cw, input int tmo, input bit exact);
        int n = 0;
        bit vseen = 0;
        adc_mode      = mode;
        cfg_cnv_width = CNVW'(cw);
        cfg_timeout   = TMOW'(tmo);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!err_timeout && n <= 3000) begin
            if (rd_valid) vseen = 1;
            @(negedge clk); n++;
        end
        check(err_timeout, "R9 error raised", err_timeout, 1);
        if (exact) check(n == cw + tmo + 2, "R9 error latency", n, cw + tmo + 2);
        check(!vseen && !rd_valid, "R9 no valid", rd_valid, 0);
        check(adc_cs_n, "R10 cs_n with error", adc_cs_n, 1);
        @(negedge clk);
        check(!err_timeout, "R9 error single cycle", err_timeout, 0);
        adc_mode = 0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(adc_rc && adc_cs_n, "R1 rc/cs_n idle high", {adc_rc, adc_cs_n}, 3);
        check(!adc_dclk && !rd_valid && !err_timeout, "R1 strobes low",
              {adc_dclk, rd_valid, err_timeout}, 0);
        check(rd_data == '0, "R1 data zero", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(adc_cs_n && adc_rc && !adc_dclk, "R1 after release",
              {adc_cs_n, adc_rc, adc_dclk}, 6);

        for (int r = 0; r < 2; r++)
            for (int d = 0; d < 4; d++)
                for (int c = 0; c < 3; c++)
                    for (int k = 0; k < 4; k++) begin
                        case (k)
                            0: w = 16'h0000;
                            1: w = 16'hFFFF;
                            2: w = 16'h8001;
                            default: w = DW'(40503 * (d + 1) + 977 * c + 7919 * r + 131);
                        endcase
                        run_txn(w, r[0], d, (c == 2) ? 3 : c, 1'b0);
                    end

        // R3: start during read, both sampling edges
        run_txn(16'h5A3C, 1'b0, 1, 1, 1'b1);
        run_txn(16'hC3A5, 1'b1, 2, 0, 1'b1);

        // R9: busy never falls, exact latency; busy never returns
        run_timeout(1, 2, 5, 1'b1);
        run_timeout(1, 0, 0, 1'b1);
        run_timeout(2, 1, 30, 1'b0);

        // R10: recovery after errors
        run_txn(16'h1234, 1'b1, 0, 0, 1'b0);
        run_txn(16'hFEDC, 1'b0, 3, 2, 1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule